// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block is the slave side of an I2C link, clocked by the system clock. It samples the open-drain SCL and SDA wires through synchronizers. It finds Start, Repeated Start and Stop conditions and shifts each byte in MSB first. Address bytes are compared with a host-programmed compare register. A mask marks compare bits as don't-care, so one slave can answer to a group of addresses. The block drives the acknowledge bit itself and pulls SCL low whenever it needs the host.

The host sees two streams and a few plain status pins. Every accepted byte goes into a one-entry receive buffer, and address bytes go there too. The buffer is offered on `rx_valid`/`rx_data` and is emptied by `rx_ready`. The block does not wait on `rx_ready`. A byte that completes while the buffer is still full is refused with NACK, and the overflow flag is set. For a read, the block raises `tx_ready` and holds SCL low until the host offers a byte on `tx_valid`/`tx_data`. That stretch is the only back-pressure the host can apply to the bus.

In 10-bit mode the host rewrites the compare register between the two address bytes. The update flag `ua` rises after each address byte and SCL stays low until that write arrives.

Top module: `i2c_addr_slave`

## Requirements
- R1: While `cfg_en` is low the block drives neither line, gives no ACK and raises no `irq`. While it is high, a fall of SDA with SCL high is a Start and a rise of SDA with SCL high is a Stop.
- R2: Bits are taken at SCL rising edges, MSB first, and the eighth bit ends the byte.
- R3: In 7-bit mode, bits [7:1] of the first byte after a Start are compared with bits [7:1] of the compare register. A `cfg_mask` bit at 1 makes that bit don't-care. On a miss there is no ACK and no `irq`, and the bus is ignored until the next Start.
- R4: When a byte is accepted and both `rx_valid` and `ovf` are clear, the byte is loaded into `rx_data` and `rx_valid` rises. SDA is held low through the ninth clock, and `irq` pulses for one cycle after the ninth SCL falling edge.
- R5: When a byte completes while `rx_valid` or `ovf` is set, the block gives no ACK and leaves `rx_data` unchanged, but `irq` still pulses. If `rx_valid` was set, `ovf` is set.
- R6: `rx_valid` clears in the cycle after `rx_ready` is seen high. `ovf` holds until `ovf_clr`.
- R7: With `cfg_ten` high, the first address byte is accepted only as `11110 b2 b1 0`, where b2 and b1 are compared with compare-register bits [2:1] under the mask. After its ninth clock `ua` rises and SCL is held low. The next `addr_we` clears `ua` and releases SCL.
- R8: The second 10-bit address byte is compared on all eight bits under the mask. When it matches, it raises `ua` and stretches SCL the same way as R7.
- R9: Bytes that follow a complete address in a write are accepted, acknowledged and delivered under R4 and R5.
- R10: A read starts in two ways. In 7-bit mode it starts with an address byte whose bit 0 is 1. In 10-bit mode it starts with a Repeated Start after a full 10-bit match, followed by a matching first byte with bit 0 = 1. In either case the block stretches SCL with `tx_ready` high until `tx_valid` and then shifts the byte out MSB first, changing SDA only while SCL is low. A master ACK requests the next byte and a master NACK releases the bus.
- R11: With `cfg_ssint` high, each Start and each Stop also pulses `irq`.
- R12: `rw` holds bit 0 of the last accepted address byte that begins a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_ten | input | 1 | 10-bit addressing mode |
| cfg_ssint | input | 1 | Also interrupt on Start and Stop |
| cfg_mask | input | 8 | Don't-care bits of the address compare |
| addr_we | input | 1 | Write strobe for the compare register |
| addr_wdata | input | 8 | New compare register value |
| ua | output | 1 | Compare register update needed (SCL held) |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| rx_data | output | 8 | Receive buffer |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Host takes the receive buffer |
| ovf | output | 1 | Overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| rw | output | 1 | Direction bit of the current transfer (1 = read) |
| tx_data | input | 8 | Byte to return to the master |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | The block wants a byte to send |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every bus-side result lands three clock edges after the SCL or SDA edge that causes it: two synchronizer stages plus the state register. This covers `rx_valid`, `rx_data` and the ACK drive after the eighth falling edge, `irq`, `ua` and the stretch after the ninth, and each transmitted bit after its falling edge. The bench master holds every SCL phase for ten cycles, samples SDA mid-high and checks results only after a full low phase, well beyond that three-edge lag. Host-side results (`ua` and `rx_valid` clearing, `ovf` clearing) appear one edge after the strobe, and each one is checked at the next falling clock edge. SDA moving while SCL is high is caught by a monitor at the pins and by a checker on the synchronized SCL level.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_HOLD, ST_TXWAIT, ST_TX, ST_TXACK, ST_DONE
  } i2cs_state_e;

  typedef enum logic [1:0] {PH_ADDR, PH_ADLO, PH_DATA} i2cs_phase_e;

  typedef enum logic [1:0] {MT_7, MT_10HI, MT_10LO} i2cs_match_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], in_i[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level_o[g] = chain[STAGES-1];
    assign rise_o[g]  = chain[STAGES-1] & ~prev;
    assign fall_o[g]  = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  i2cs_match_e       kind_i,
  output logic              hit_o
);
  logic [BYTE_W-1:0] diff;

  always_comb begin
    diff = (byte_i ^ addr_i) & ~mask_i;
    case (kind_i)
      MT_7:    hit_o = (diff[BYTE_W-1:1] == '0);
      MT_10HI: hit_o = (byte_i[BYTE_W-1:BYTE_W-5] == TEN_PREFIX) && (diff[2:1] == 2'b00);
      MT_10LO: hit_o = (diff == '0);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2cs_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RESET_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_ten,
  input  logic              cfg_ssint,
  input  logic [BYTE_W-1:0] cfg_mask,
  input  logic              addr_we,
  input  logic [BYTE_W-1:0] addr_wdata,
  output logic              ua,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              ovf,
  input  logic              ovf_clr,
  output logic              rw,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              irq
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // line conditioning: lane 0 = SCL, lane 1 = SDA
  logic [1:0] lvl, rise, fall;
  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .in_i({sda_i, scl_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = lvl[0];
  assign sda_s     = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = fall[1] & scl_s;
  assign stop_det  = rise[1] & scl_s;

  i2cs_state_e       state;
  i2cs_phase_e       phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, txsh, addr_q, rx_q;
  logic              ack_drive, hold_next, rd_next, ten_done, mack;
  logic              bf, ovf_q, rw_q, ua_q, irq_q;

  // address compare
  i2cs_match_e kind;
  logic        hit, accept, room;

  always_comb begin
    if (phase == PH_ADLO)  kind = MT_10LO;
    else if (cfg_ten)      kind = MT_10HI;
    else                   kind = MT_7;
  end

  i2cs_addr_match u_match (
    .byte_i(sh), .addr_i(addr_q), .mask_i(cfg_mask), .kind_i(kind), .hit_o(hit)
  );

  always_comb begin
    case (phase)
      PH_ADDR: accept = cfg_ten ? (hit && (!sh[0] || ten_done)) : hit;
      PH_ADLO: accept = hit;
      default: accept = 1'b1;
    endcase
  end

  assign room = !bf && !ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      cnt       <= '0;
      sh        <= '0;
      txsh      <= '0;
      addr_q    <= RESET_ADDR;
      rx_q      <= '0;
      ack_drive <= 1'b0;
      hold_next <= 1'b0;
      rd_next   <= 1'b0;
      ten_done  <= 1'b0;
      mack      <= 1'b0;
      bf        <= 1'b0;
      ovf_q     <= 1'b0;
      rw_q      <= 1'b0;
      ua_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (addr_we)         addr_q <= addr_wdata;
      if (rx_ready && bf)  bf     <= 1'b0;
      if (ovf_clr)         ovf_q  <= 1'b0;

      if (!cfg_en) begin
        state <= ST_IDLE;
        ua_q  <= 1'b0;
      end else if (start_det) begin
        state <= ST_RX;
        phase <= PH_ADDR;
        cnt   <= '0;
        ua_q  <= 1'b0;
        irq_q <= cfg_ssint;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        ten_done <= 1'b0;
        ua_q     <= 1'b0;
        irq_q    <= cfg_ssint;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (accept) begin
                if (room) begin
                  rx_q <= sh;
                  bf   <= 1'b1;
                end else if (bf) begin
                  ovf_q <= 1'b1;
                end
                ack_drive <= room;
                state     <= ST_ACK;
                case (phase)
                  PH_ADDR: begin
                    rw_q      <= sh[0];
                    hold_next <= cfg_ten && !sh[0];
                    rd_next   <= sh[0];
                  end
                  PH_ADLO: begin
                    hold_next <= 1'b1;
                    rd_next   <= 1'b0;
                    ten_done  <= room;
                  end
                  default: begin
                    hold_next <= 1'b0;
                    rd_next   <= 1'b0;
                  end
                endcase
              end else begin
                state <= ST_DONE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              irq_q <= 1'b1;
              if (!ack_drive) begin
                state <= ST_DONE;
              end else if (hold_next) begin
                state <= ST_HOLD;
                ua_q  <= 1'b1;
                phase <= (phase == PH_ADDR) ? PH_ADLO : PH_DATA;
              end else if (rd_next) begin
                state <= ST_TXWAIT;
              end else begin
                state <= ST_RX;
                cnt   <= '0;
                phase <= PH_DATA;
              end
            end
          end
          ST_HOLD: begin
            if (addr_we) begin
              ua_q  <= 1'b0;
              state <= ST_RX;
              cnt   <= '0;
            end
          end
          ST_TXWAIT: begin
            if (tx_valid) begin
              txsh  <= tx_data;
              cnt   <= '0;
              state <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) state <= ST_TXACK;
              else                 txsh  <= {txsh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack <= !sda_s;
            end else if (scl_fall) begin
              irq_q <= 1'b1;
              state <= mack ? ST_TXWAIT : ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe   = cfg_en && (state == ST_HOLD || state == ST_TXWAIT);
  assign sda_oe   = cfg_en && ((state == ST_ACK && ack_drive) ||
                               (state == ST_TX && !txsh[BYTE_W-1]));
  assign tx_ready = cfg_en && (state == ST_TXWAIT);
  assign rx_data  = rx_q;
  assign rx_valid = bf;
  assign ovf      = ovf_q;
  assign rw       = rw_q;
  assign ua       = ua_q;
  assign irq      = irq_q;
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic scl_lvl,
  input logic scl_oe,
  input logic sda_oe,
  input logic ua,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic ovf,
  input logic ovf_clr
);
  a_r7_ua_stretches: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    ua |-> scl_oe);

  a_r10_tx_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    tx_ready |-> scl_oe);

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    !$stable(sda_oe) |-> !scl_lvl);

  a_r4_load_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> sda_oe);

  a_r6_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_valid);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
endmodule

bind i2c_addr_slave i2cs_checks u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .scl_lvl(scl_s),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .ua(ua), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  localparam int H = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cfg_en, cfg_ten, cfg_ssint, addr_we, rx_ready, ovf_clr, tx_valid;
  logic [7:0] cfg_mask, addr_wdata, tx_data;
  logic       ua, scl_oe, sda_oe, rx_valid, ovf, rw, tx_ready, irq;
  logic [7:0] rx_data;
  logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic       scl_line, sda_line;
  assign scl_line = !(m_scl_lo || scl_oe);
  assign sda_line = !(m_sda_lo || sda_oe);

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ten(cfg_ten), .cfg_ssint(cfg_ssint),
    .cfg_mask(cfg_mask), .addr_we(addr_we), .addr_wdata(addr_wdata), .ua(ua),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .ovf(ovf),
    .ovf_clr(ovf_clr), .rw(rw), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .irq(irq)
  );

  int n_chk = 0, n_err = 0, irq_cnt = 0, edge_bad = 0;
  logic sda_oe_d = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    if (irq === 1'b1) irq_cnt = irq_cnt + 1;
    if (sda_oe !== sda_oe_d && scl_line) edge_bad = edge_bad + 1;
    sda_oe_d = sda_oe;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---- bus master model (open drain, honours stretching) ----
  task automatic rel_scl();
    m_scl_lo = 1'b0;
    cyc(1);
    while (!scl_line) cyc(1);
  endtask
  task automatic m_start();
    m_sda_lo = 1'b1; cyc(H); m_scl_lo = 1'b1; cyc(H);
  endtask
  task automatic m_rstart();
    m_sda_lo = 1'b0; cyc(H); rel_scl(); cyc(H); m_sda_lo = 1'b1; cyc(H); m_scl_lo = 1'b1; cyc(H);
  endtask
  task automatic m_stop();
    m_sda_lo = 1'b1; cyc(H); rel_scl(); cyc(H); m_sda_lo = 1'b0; cyc(H);
  endtask
  task automatic m_bit_out(logic b);
    m_sda_lo = !b; cyc(H); rel_scl(); cyc(H); m_scl_lo = 1'b1; cyc(H);
  endtask
  task automatic m_bit_in(output logic b);
    m_sda_lo = 1'b0; cyc(H); rel_scl(); cyc(H/2); b = sda_line; cyc(H/2); m_scl_lo = 1'b1; cyc(H);
  endtask
  task automatic m_write(logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
    m_bit_in(nack);
  endtask
  task automatic m_read(logic last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_in(v[i]);
    m_bit_out(last);
  endtask

  // ---- host side ----
  task automatic h_addr(logic [7:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask
  task automatic h_pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask
  task automatic h_tx(logic [7:0] v);
    @(negedge clk); tx_valid = 1'b1; tx_data = v;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check("reset rx_valid", rx_valid, 0);
    check("reset ovf", ovf, 0);
    check("reset ua", ua, 0);
    check("reset bus drive", {scl_oe, sda_oe, tx_ready}, 0);
  endtask

  task automatic t_write7();
    logic nack; int i0;
    h_addr(8'h5A);
    i0 = irq_cnt;
    m_start();
    m_write(8'h5A, nack);
    check("R3 7-bit match acked", nack, 0);
    check("R4 address byte in buffer", {rx_valid, rx_data}, {1'b1, 8'h5A});
    check("R4 irq after ninth clock", irq_cnt - i0, 1);
    check("R12 rw write", rw, 0);
    h_pop();
    check("R6 pop clears rx_valid", rx_valid, 0);
    m_write(8'hC3, nack);
    check("R9 data acked", nack, 0);
    check("R2 data msb first", rx_data, 8'hC3);
    h_pop();
    m_stop();
    check("R11 no start/stop irq when off", irq_cnt - i0, 2);
  endtask

  task automatic t_mismatch();
    logic nack; int i0;
    i0 = irq_cnt;
    m_start();
    m_write(8'h40, nack);
    check("R3 miss not acked", nack, 1);
    m_write(8'h5A, nack);
    check("R3 ignored until start", nack, 1);
    check("R3 miss no irq no load", {irq_cnt - i0, 31'(rx_valid)}, 0);
    m_stop();
  endtask

  task automatic t_mask();
    logic nack;
    cfg_mask = 8'h06;
    m_start();
    m_write(8'h5C, nack);
    check("R3 masked bits ignored", nack, 0);
    h_pop();
    m_stop();
    cfg_mask = 8'h00;
  endtask

  task automatic t_read7();
    logic nack; logic [7:0] v;
    m_start();
    m_write(8'h5B, nack);
    check("R10 read address acked", nack, 0);
    check("R12 rw read", rw, 1);
    check("R10 tx_ready with stretch", {tx_ready, scl_oe}, 2'b11);
    h_pop();
    h_tx(8'h81);
    m_read(1'b1, v);
    check("R10 byte shifted out", v, 8'h81);
    m_stop();
    check("R10 bus released after nack", {tx_ready, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_overflow();
    logic nack; int i0;
    m_start();
    m_write(8'h5A, nack);
    check("R4 address acked", nack, 0);
    i0 = irq_cnt;
    m_write(8'h11, nack);
    check("R5 full buffer nacked", nack, 1);
    check("R5 buffer unchanged", rx_data, 8'h5A);
    check("R5 ovf set", ovf, 1);
    check("R5 irq still raised", irq_cnt - i0, 1);
    m_stop();
    h_pop();
    check("R6 ovf survives pop", {ovf, rx_valid}, 2'b10);
    m_start();
    m_write(8'h5A, nack);
    check("R5 nack while ovf", {nack, rx_valid}, 2'b10);
    m_stop();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R6 ovf_clr clears", ovf, 0);
  endtask

  task automatic t_ten();
    logic nack; logic [7:0] v; int i0;
    cfg_ten = 1'b1;
    h_addr(8'hF2);
    i0 = irq_cnt;
    m_start();
    m_write(8'hF2, nack);
    check("R7 high byte acked", nack, 0);
    check("R7 ua and stretch", {ua, scl_oe}, 2'b11);
    cyc(40);
    check("R7 stretch held", {ua, scl_oe, scl_line}, 3'b110);
    h_pop();
    h_addr(8'h37);
    check("R7 write clears ua", {ua, scl_oe}, 0);
    m_write(8'h37, nack);
    check("R8 low byte acked", nack, 0);
    check("R8 ua again", {ua, scl_oe, rx_data}, {2'b11, 8'h37});
    h_pop();
    h_addr(8'hF2);
    m_write(8'h99, nack);
    check("R9 10-bit data acked", {nack, rx_data}, {1'b0, 8'h99});
    h_pop();
    m_rstart();
    m_write(8'hF3, nack);
    check("R10 10-bit read acked", nack, 0);
    check("R12 rw after restart", rw, 1);
    check("R10 10-bit tx_ready", tx_ready, 1);
    h_pop();
    h_tx(8'hA5);
    m_read(1'b0, v);
    check("R10 first byte", v, 8'hA5);
    check("R10 next byte requested", tx_ready, 1);
    h_tx(8'h3C);
    m_read(1'b1, v);
    check("R10 second byte", v, 8'h3C);
    m_stop();
    check("R10 released", tx_ready, 0);
    check("R4 irq per byte", irq_cnt - i0, 6);
    check("R10 sda steady while scl high", edge_bad, 0);
    cfg_ten = 1'b0;
    h_addr(8'h5A);
  endtask

  task automatic t_ssint();
    int i0;
    cfg_ssint = 1'b1;
    i0 = irq_cnt;
    m_start();
    check("R11 start irq", irq_cnt - i0, 1);
    m_sda_lo = 1'b1; cyc(H); rel_scl(); cyc(H); m_sda_lo = 1'b0; cyc(H);
    check("R11 stop irq", irq_cnt - i0, 2);
    cfg_ssint = 1'b0;
  endtask

  task automatic t_disabled();
    logic nack; int i0;
    cfg_en = 1'b0;
    i0 = irq_cnt;
    m_start();
    m_write(8'h5A, nack);
    check("R1 disabled no ack", nack, 1);
    check("R1 disabled silent", {irq_cnt - i0, 31'(rx_valid)}, 0);
    m_stop();
    cfg_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b1; cfg_ten = 1'b0; cfg_ssint = 1'b0; cfg_mask = 8'h00;
    addr_we = 1'b0; addr_wdata = 8'h00; rx_ready = 1'b0; ovf_clr = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_write7();
    t_mismatch();
    t_mask();
    t_read7();
    t_overflow();
    t_ten();
    t_ssint();
    t_disabled();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule